// File: doc/BRIEF.md
# Single-Byte SPI Master with Selectable Clock Mode

This block drives one byte out of MOSI and pulls one byte in from MISO during each transfer. It generates the serial clock, frames the exchange with an active-low select line, and reports completion to the parallel side. A host places a byte on `tx_byte`, picks a timing mode and a clock divider, and pulses `start`. The block raises `busy`, runs sixteen serial clock edges, and then pulses `done` for one cycle. The received byte is on `rx_byte` in that same cycle.

The two-bit mode packs clock polarity into its low bit and clock phase into its high bit. Mode 1 is polarity 1 with phase 0, and mode 2 is polarity 0 with phase 1. Each half period of the serial clock lasts (divider+1) system clocks. Mode, divider and transmit byte are captured when a transfer is accepted.

Top module: `spi_byte_master`

## Requirements
- R1: `mode[0]` is the clock polarity and `mode[1]` is the clock phase. Outside a transfer, `sclk` rests at the polarity captured at the most recent accepted start, or 0 after reset. From the cycle `ss_n` falls, `sclk` already sits at the new polarity.
- R2: With phase 0, the first MOSI bit is valid in the cycle `ss_n` falls. MISO is registered on each leading `sclk` edge (odd edges 1,3,..,15). MOSI moves to the next bit on each trailing edge.
- R3: With phase 1, MOSI presents its next bit from each leading edge. MISO is registered on each trailing edge (even edges 2,4,..,16).
- R4: Both lines carry eight bits, bit 7 first and bit 0 last. `rx_byte` equals the byte the slave sent.
- R5: Every `sclk` half period, including the gap from `ss_n` falling to the first edge, lasts exactly divider+1 system clocks.
- R6: `ss_n` falls in the accept cycle and stays low across exactly 16 `sclk` edges. It rises divider+1 clocks after the 16th edge, which is 17*(divider+1) clocks after it fell.
- R7: `done` is high for exactly one cycle, in the cycle `ss_n` rises. `rx_byte` is valid in that cycle, and `busy` is already low.
- R8: A `start` pulse while `busy` is high has no effect on the running transfer's bits, timing or configuration.
- R9: Changes to `mode`, `divider` and `tx_byte` after a start is accepted do not alter that transfer.
- R10: After reset, `ss_n`=1, `sclk`=0, `mosi`=0, and `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| mode | input | 2 | Bit 0 polarity, bit 1 phase |
| divider | input | DIV_W | Half period is divider+1 clocks |
| tx_byte | input | BITS | Byte to send |
| rx_byte | output | BITS | Byte received, valid with done |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The bench sweeps all four modes, divider values 0 to 3 and several byte patterns against a behavioural slave that follows the requirements. It checks the bytes received on both sides and every half-period length.

The divider-0 case exposes an off-by-one in the half-period counter, because the gaps would come out as zero or two clocks. Swapping the polarity and phase bits makes the slave capture shifted bytes in modes 1 and 2. A missing suppression of the first phase-1 shift loses bit 7.

Start pulses injected mid-transfer, together with configuration inputs scrambled right after acceptance, catch a design that restarts or reads live inputs; such a design would corrupt the byte or stretch the select window. The bench also checks the last gap between the 16th edge and `ss_n` rising, and that `done` coincides with that rise; a design that ends early would truncate bit 0.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int BITS  = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [DIV_W-1:0] divider,
  input  logic [BITS-1:0]  tx_byte,
  output logic [BITS-1:0]  rx_byte,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             ss_n
);
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES + 1);

  logic             busy_q, done_q, ss_q, sclk_q;
  logic [1:0]       mode_q;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic [EW-1:0]    edge_q;
  logic [BITS-1:0]  tx_sh, rx_sh, rx_q;

  wire tick      = busy_q && (cnt_q == div_q);
  wire last      = (edge_q == EW'(EDGES));
  wire next_lead = ~edge_q[0];
  wire phase     = mode_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      ss_q   <= 1'b1;
      sclk_q <= 1'b0;
      mode_q <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
      edge_q <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          ss_q   <= 1'b0;
          mode_q <= mode;
          div_q  <= divider;
          tx_sh  <= tx_byte;
          cnt_q  <= '0;
          edge_q <= '0;
          sclk_q <= mode[0];
        end
      end else if (!tick) begin
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
        if (last) begin
          busy_q <= 1'b0;
          ss_q   <= 1'b1;
          done_q <= 1'b1;
          rx_q   <= rx_sh;
        end else begin
          sclk_q <= ~sclk_q;
          edge_q <= edge_q + 1'b1;
          if (next_lead ^ phase)
            rx_sh <= {rx_sh[BITS-2:0], miso};
          else if (next_lead == 1'b0 || edge_q != '0)
            tx_sh <= tx_sh << 1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign ss_n    = ss_q;
  assign sclk    = sclk_q;
  assign rx_byte = rx_q;
  assign mosi    = busy_q ? tx_sh[BITS-1] : 1'b0;

  assert_select_tracks_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q == !ss_q);
  assert_edge_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q <= EW'(EDGES));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  assert_idle_clock_still_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && $past(!busy_q)) |-> $stable(sclk_q));
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !(tick && last)) |=> ($stable(mode_q) && $stable(div_q)));
endmodule

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    mode = '0;
  logic [DW-1:0] divider = '0;
  logic [7:0]    tx_byte = '0;
  logic [7:0]    rx_byte;
  logic          busy, done, sclk, mosi, ss_n;
  logic          miso = 1'b0;

  int vectors = 0;
  int errors  = 0;

  always #2 clk = ~clk;

  spi_byte_master #(.BITS(8), .DIV_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .divider(divider),
    .tx_byte(tx_byte), .rx_byte(rx_byte), .busy(busy), .done(done),
    .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] m, input int d, input logic [7:0] tx,
                     input logic [7:0] sb, input bit inject);
    int total = 17 * (d + 1);
    bit ph = m[1];
    bit prev_ss = 1'b1;
    bit prev_sclk;
    int edges = 0, last_c = 0, gmin = 1000, gmax = -1;
    int fall_c = -1, rise_c = -1, done_c = -1, done_n = 0, e16_c = -1;
    int sidx;
    logic [7:0] got = '0, rx_at = '0;
    bit busy_at = 1'b1;
    @(negedge clk);
    mode = m; divider = DW'(d); tx_byte = tx; start = 1'b1;
    prev_sclk = sclk;
    @(negedge clk);
    start = 1'b0; mode = ~m; divider = ~DW'(d); tx_byte = ~tx;
    sidx = 7;
    for (int c = 0; c <= total + 3; c++) begin
      if (c > 0) @(negedge clk);
      if (inject && c == 5) begin start = 1'b1; mode = 2'd3 ^ m; tx_byte = 8'h00; end
      if (inject && c == 6) start = 1'b0;
      if (c == 0) begin
        check(sclk == m[0], "R1 select-time sclk level", sclk, m[0]);
        if (!ph) check(mosi == tx[7], "R2 first bit at select", mosi, tx[7]);
      end
      if (prev_ss && !ss_n) begin
        fall_c = c;
        if (!ph) begin miso = sb[7]; sidx = 6; end
      end
      if (!prev_ss && !ss_n && sclk != prev_sclk) begin
        edges++;
        if (c - last_c < gmin) gmin = c - last_c;
        if (c - last_c > gmax) gmax = c - last_c;
        last_c = c;
        if (edges == 16) e16_c = c;
        if ((edges % 2 == 1) ^ ph) got = {got[6:0], mosi};
        else if (sidx >= 0) begin miso = sb[sidx]; sidx--; end
      end
      if (done) begin done_n++; done_c = c; rx_at = rx_byte; busy_at = busy; end
      if (!prev_ss && ss_n) rise_c = c;
      prev_ss = ss_n;
      prev_sclk = sclk;
    end
    check(got == tx, "R4 slave got mosi byte (R2/R3/R9)", got, tx);
    check(rx_at == sb, "R4 rx_byte at done (R2/R3)", rx_at, sb);
    check(edges == 16, "R6 edge count", edges, 16);
    check(gmin == d + 1 && gmax == d + 1, "R5 half period", gmax, d + 1);
    check(fall_c == 0, "R6 select falls at accept", fall_c, 0);
    check(rise_c == total, "R6 select rises (R8/R9)", rise_c, total);
    check(rise_c - e16_c == d + 1, "R6 tail gap", rise_c - e16_c, d + 1);
    check(done_n == 1 && done_c == total, "R7 done pulse", done_c, total);
    check(busy_at == 1'b0, "R7 busy low at done", busy_at, 0);
    check(sclk == m[0], "R1 idle sclk level", sclk, m[0]);
    if (inject) check(got == tx && rise_c == total, "R8 start while busy ignored", got, tx);
  endtask

  initial begin
    automatic logic [7:0] pats[4] = '{8'hA5, 8'h3C, 8'h01, 8'hFE};
    repeat (3) @(negedge clk);
    check(ss_n == 1'b1, "R10 ss_n reset", ss_n, 1);
    check(sclk == 1'b0, "R10 sclk reset", sclk, 0);
    check(mosi == 1'b0, "R10 mosi reset", mosi, 0);
    check(busy == 1'b0 && done == 1'b0, "R10 busy/done reset", {busy, done}, 0);
    rst_n = 1'b1;
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 4; d++)
        for (int p = 0; p < 4; p++)
          run(2'(m), d, pats[p], {pats[p][3:0], pats[p][7:4]} ^ 8'h5A, p == 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule